// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block holds the host-programmed control state for a four-channel DMA controller: one mask bit per channel, one software request bit per channel and a six-bit mode word per channel. The host issues commands through a write strobe, a three-bit command code and an eight-bit data byte. Mask and request bits are changed one at a time by a byte that carries a channel number and a set/clear flag. The mask can also be loaded as a whole, cleared as a whole, or forced on by a master clear.

End-of-process pulses from the transfer engine update the state. A channel that is not set up to autoinitialize masks itself, and every channel that ends drops its software request. The block combines the hardware request inputs with the mask and the software requests, and passes the result and the decoded mode fields to the priority logic.

Readback goes through a read strobe with the same command code. Unused bits come back as ones. Mode words are read through an internal pointer that steps to the next channel on each mode read.

Top module: `dmac_ctl_regs`

## Requirements
- R1: After reset the mask is all ones, the software requests are all zero, and the mode read pointer is at channel 0.
- R2: Command code 0 (single mask bit) uses data bits 1:0 as the channel and bit 2 as the new value, 1 for set and 0 for clear. Only that channel's mask bit changes, and data bits 7:3 have no effect.
- R3: Command code 1 (load mask) copies data bits 3:0 into the mask bits of channels 0 to 3. Data bits 7:4 have no effect.
- R4: Command code 2 clears all four mask bits. A mask read (read code 0) returns ones in bits 7:4 and mask bits 3:0.
- R5: Command code 5 (master clear) sets all mask bits, clears all software requests and returns the mode read pointer to channel 0. It leaves the mode words unchanged.
- R6: An end-of-process pulse on a channel whose autoinitialize bit is 0 sets that channel's mask bit on the next clock. A channel whose autoinitialize bit is 1 keeps its mask bit.
- R7: When an end-of-process mask update and a host mask command fall in the same cycle, the end-of-process update wins for that channel.
- R8: Command code 3 sets or clears one software request bit, with the channel in data bits 1:0 and the value in bit 2. A request read (read code 3) returns ones in bits 7:4 and the request bits in 3:0.
- R9: An end-of-process pulse clears that channel's software request bit on the next clock, whatever the autoinitialize setting.
- R10: Command code 4 writes the mode of the channel given in data bits 1:0. The fields are: bits 3:2 transfer type (00 verify, 01 write, 10 read, 11 illegal), bit 4 autoinitialize, bit 5 decrement, bits 7:6 operating mode (00 demand, 01 single, 10 block, 11 cascade).
- R11: A mode read (read code 4) returns the pointed channel's bits 7:2 with ones in bits 1:0, then moves the pointer to the next channel, wrapping from 3 to 0.
- R12: The effective request of each channel is its hardware request gated by a clear mask bit, ORed with its software request bit. A mask bit does not block a software request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Command write strobe |
| rd_en | input | 1 | Register read strobe |
| cmd_sel | input | 3 | Command or read code |
| wdata | input | 8 | Command data byte |
| rdata | output | 8 | Readback byte, valid in the cycle rd_en is high |
| eop | input | 4 | Per-channel end-of-process pulse |
| hw_req | input | 4 | Per-channel hardware request |
| mask_o | output | 4 | Mask bits |
| sw_req_o | output | 4 | Software request bits |
| eff_req_o | output | 4 | Combined request to the priority logic |
| xfer_type_o | output | 8 | Transfer type, two bits per channel |
| autoinit_o | output | 4 | Autoinitialize enable per channel |
| decr_o | output | 4 | Address decrement select per channel |
| op_mode_o | output | 8 | Operating mode, two bits per channel |

## Verification
The bench writes single mask bit commands with junk in the upper data bits. A decoder that looked at those bits would change the wrong channel or skip the update. It fires end-of-process on every channel at once, with some channels autoinitializing. A design that ignored the autoinitialize bit would mask those channels, and one that kept the software request would leave it set. It issues a clear-mask command in the same cycle as an end-of-process pulse, which catches a design that lets the host write win. It reads the mode words five times in a row and then after a master clear. A design with a broken wrap or a pointer that master clear does not reset returns the wrong channel's mode.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;

  localparam int DW = 8;

  typedef enum logic [2:0] {
    CMD_MASK_BIT = 3'd0,
    CMD_MASK_ALL = 3'd1,
    CMD_MASK_CLR = 3'd2,
    CMD_REQ_BIT  = 3'd3,
    CMD_MODE     = 3'd4,
    CMD_MCLR     = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    XF_VERIFY  = 2'd0,
    XF_WRITE   = 2'd1,
    XF_READ    = 2'd2,
    XF_ILLEGAL = 2'd3
  } xfer_e;

  typedef enum logic [1:0] {
    OM_DEMAND  = 2'd0,
    OM_SINGLE  = 2'd1,
    OM_BLOCK   = 2'd2,
    OM_CASCADE = 2'd3
  } opmode_e;

  // Field order matches data bits 7:2 of a mode command.
  typedef struct packed {
    opmode_e op;
    logic    decr;
    logic    autoinit;
    xfer_e   xfer;
  } chmode_t;

endpackage

// File: rtl/dmac_rst_sync.sv
module dmac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dmac_mask_reg.sv
module dmac_mask_reg #(
  parameter  int N_CH = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclr,
  input  logic            clr_all,
  input  logic            wr_all,
  input  logic            bit_wr,
  input  logic [CH_W-1:0] bit_sel,
  input  logic            bit_val,
  input  logic [N_CH-1:0] all_val,
  input  logic [N_CH-1:0] eop_set,
  output logic [N_CH-1:0] mask_q
);

  logic [N_CH-1:0] mask_d;
  logic            mask_en;

  always_comb begin
    mask_d = mask_q;
    if (mclr) begin
      mask_d = '1;
    end else begin
      if (clr_all)     mask_d = '0;
      else if (wr_all) mask_d = all_val;
      else if (bit_wr) mask_d[bit_sel] = bit_val;
      // End-of-process masking has the last word over host commands.
      mask_d = mask_d | eop_set;
    end
  end

  assign mask_en = mclr | clr_all | wr_all | bit_wr | (|eop_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

endmodule

// File: rtl/dmac_req_reg.sv
module dmac_req_reg #(
  parameter  int N_CH = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclr,
  input  logic            bit_wr,
  input  logic [CH_W-1:0] bit_sel,
  input  logic            bit_val,
  input  logic [N_CH-1:0] eop,
  output logic [N_CH-1:0] req_q
);

  logic [N_CH-1:0] req_d;
  logic            req_en;

  always_comb begin
    req_d = req_q;
    if (mclr) begin
      req_d = '0;
    end else begin
      if (bit_wr) req_d[bit_sel] = bit_val;
      req_d = req_d & ~eop;
    end
  end

  assign req_en = mclr | bit_wr | (|eop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= '0;
    else if (req_en) req_q <= req_d;
  end

endmodule

// File: rtl/dmac_mode_bank.sv
module dmac_mode_bank
  import dmac_ctl_pkg::*;
#(
  parameter  int N_CH = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclr,
  input  logic            wr,
  input  logic [CH_W-1:0] wr_sel,
  input  chmode_t         wr_mode,
  input  logic            rd_adv,
  output chmode_t         modes [N_CH],
  output logic [CH_W-1:0] rd_ptr
);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic mode_en;
    assign mode_en = wr && (wr_sel == CH_W'(ch));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       modes[ch] <= '0;
      else if (mode_en) modes[ch] <= wr_mode;
    end
  end

  logic [CH_W-1:0] ptr_d;
  logic            ptr_en;

  always_comb begin
    ptr_d = rd_ptr;
    if (mclr)        ptr_d = '0;
    else if (rd_adv) ptr_d = rd_ptr + 1'b1;
  end

  assign ptr_en = mclr | rd_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_ptr <= '0;
    else if (ptr_en) rd_ptr <= ptr_d;
  end

endmodule

// File: rtl/dmac_ctl_regs.sv
module dmac_ctl_regs
  import dmac_ctl_pkg::*;
#(
  parameter int N_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        cmd_sel,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [N_CH-1:0]   eop,
  input  logic [N_CH-1:0]   hw_req,
  output logic [N_CH-1:0]   mask_o,
  output logic [N_CH-1:0]   sw_req_o,
  output logic [N_CH-1:0]   eff_req_o,
  output logic [2*N_CH-1:0] xfer_type_o,
  output logic [N_CH-1:0]   autoinit_o,
  output logic [N_CH-1:0]   decr_o,
  output logic [2*N_CH-1:0] op_mode_o
);

  localparam int CH_W  = $clog2(N_CH);
  localparam int PAD_W = DW - N_CH;

  logic rst_sync_n;

  dmac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Command decode
  cmd_e cmd;
  logic do_mclr, do_mclr_all, do_mwr_all, do_mbit, do_rbit, do_mode;
  logic rd_mode;

  assign cmd         = cmd_e'(cmd_sel);
  assign do_mclr     = wr_en && (cmd == CMD_MCLR);
  assign do_mclr_all = wr_en && (cmd == CMD_MASK_CLR);
  assign do_mwr_all  = wr_en && (cmd == CMD_MASK_ALL);
  assign do_mbit     = wr_en && (cmd == CMD_MASK_BIT);
  assign do_rbit     = wr_en && (cmd == CMD_REQ_BIT);
  assign do_mode     = wr_en && (cmd == CMD_MODE);
  assign rd_mode     = rd_en && (cmd == CMD_MODE);

  chmode_t         modes [N_CH];
  logic [CH_W-1:0] rd_ptr;
  logic [N_CH-1:0] eop_mask_set;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_flat
    assign xfer_type_o[2*ch +: 2] = modes[ch].xfer;
    assign op_mode_o[2*ch +: 2]   = modes[ch].op;
    assign autoinit_o[ch]         = modes[ch].autoinit;
    assign decr_o[ch]             = modes[ch].decr;
  end

  assign eop_mask_set = eop & ~autoinit_o;

  dmac_mask_reg #(.N_CH(N_CH)) u_mask (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mclr    (do_mclr),
    .clr_all (do_mclr_all),
    .wr_all  (do_mwr_all),
    .bit_wr  (do_mbit),
    .bit_sel (wdata[CH_W-1:0]),
    .bit_val (wdata[CH_W]),
    .all_val (wdata[N_CH-1:0]),
    .eop_set (eop_mask_set),
    .mask_q  (mask_o)
  );

  dmac_req_reg #(.N_CH(N_CH)) u_req (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mclr    (do_mclr),
    .bit_wr  (do_rbit),
    .bit_sel (wdata[CH_W-1:0]),
    .bit_val (wdata[CH_W]),
    .eop     (eop),
    .req_q   (sw_req_o)
  );

  dmac_mode_bank #(.N_CH(N_CH)) u_mode (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mclr    (do_mclr),
    .wr      (do_mode),
    .wr_sel  (wdata[CH_W-1:0]),
    .wr_mode (chmode_t'(wdata[DW-1:CH_W])),
    .rd_adv  (rd_mode),
    .modes   (modes),
    .rd_ptr  (rd_ptr)
  );

  assign eff_req_o = (hw_req & ~mask_o) | sw_req_o;

  // Readback mux
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (cmd)
        CMD_MASK_BIT: rdata = {{PAD_W{1'b1}}, mask_o};
        CMD_REQ_BIT:  rdata = {{PAD_W{1'b1}}, sw_req_o};
        CMD_MODE:     rdata = {modes[rd_ptr], {CH_W{1'b1}}};
        default:      rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dmac_ctl_regs_chk.sv
module dmac_ctl_regs_chk #(
  parameter int N_CH = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [2:0]      cmd_sel,
  input logic [7:0]      rdata,
  input logic [N_CH-1:0] eop,
  input logic [N_CH-1:0] mask_o,
  input logic [N_CH-1:0] sw_req_o,
  input logic [N_CH-1:0] autoinit_o
);

  logic mask_cmd;
  assign mask_cmd = wr_en && (cmd_sel == 3'd0 || cmd_sel == 3'd1 ||
                              cmd_sel == 3'd2 || cmd_sel == 3'd5);

  p_mclr_sets_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd_sel == 3'd5) |=> (mask_o == '1 && sw_req_o == '0));

  p_clear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cmd_sel == 3'd2 && eop == '0) |=> (mask_o == '0));

  p_eop_masks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(eop & ~autoinit_o)) |=>
      ((mask_o & $past(eop & ~autoinit_o)) == $past(eop & ~autoinit_o)));

  p_eop_drops_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|eop) |=> ((sw_req_o & $past(eop)) == '0));

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mask_cmd && eop == '0) |=> $stable(mask_o));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (cmd_sel == 3'd3 || cmd_sel == 3'd5)) && eop == '0)
      |=> $stable(sw_req_o));

  p_mode_pad_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cmd_sel == 3'd4) |-> (rdata[1:0] == 2'b11));

  p_mask_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cmd_sel == 3'd0) |-> (rdata[7:4] == 4'hF));

endmodule

bind dmac_ctl_regs dmac_ctl_regs_chk #(.N_CH(N_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .cmd_sel    (cmd_sel),
  .rdata      (rdata),
  .eop        (eop),
  .mask_o     (mask_o),
  .sw_req_o   (sw_req_o),
  .autoinit_o (autoinit_o)
);

// File: tb/tb_dmac_ctl_regs.sv
module tb_dmac_ctl_regs;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en;
  logic [2:0] cmd_sel;
  logic [7:0] wdata, rdata;
  logic [3:0] eop, hw_req;
  logic [3:0] mask_o, sw_req_o, eff_req_o, autoinit_o, decr_o;
  logic [7:0] xfer_type_o, op_mode_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dmac_ctl_regs dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .cmd_sel(cmd_sel), .wdata(wdata), .rdata(rdata), .eop(eop),
    .hw_req(hw_req), .mask_o(mask_o), .sw_req_o(sw_req_o),
    .eff_req_o(eff_req_o), .xfer_type_o(xfer_type_o),
    .autoinit_o(autoinit_o), .decr_o(decr_o), .op_mode_o(op_mode_o)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_cmd(logic [2:0] c, logic [7:0] d, logic [3:0] e = 4'h0);
    @(negedge clk);
    wr_en = 1'b1; cmd_sel = c; wdata = d; eop = e;
    @(negedge clk);
    wr_en = 1'b0; eop = 4'h0;
  endtask

  task automatic rd_reg(logic [2:0] c, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; cmd_sel = c;
    #2 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 mask after reset", {4'h0, mask_o}, 8'h0F);
    chk("R1 request after reset", {4'h0, sw_req_o}, 8'h00);
    rd_reg(3'd0, v);
    chk("R1 mask readback after reset", v, 8'hFF);
  endtask

  task automatic t_mask_bits;
    logic [7:0] v;
    wr_cmd(3'd0, 8'hF9);                 // ch1 clear, junk in 7:3
    chk("R2 clear ch1 with junk bits", {4'h0, mask_o}, 8'h0D);
    wr_cmd(3'd0, 8'h03);                 // ch3 clear
    chk("R2 clear ch3", {4'h0, mask_o}, 8'h05);
    wr_cmd(3'd0, 8'h05);                 // ch1 set
    chk("R2 set ch1", {4'h0, mask_o}, 8'h07);
    rd_reg(3'd0, v);
    chk("R2 mask readback", v, 8'hF7);
  endtask

  task automatic t_mask_all;
    wr_cmd(3'd1, 8'hA6);
    chk("R3 load mask", {4'h0, mask_o}, 8'h06);
  endtask

  task automatic t_mask_clear;
    logic [7:0] v;
    wr_cmd(3'd2, 8'hFF);
    chk("R4 clear-all mask", {4'h0, mask_o}, 8'h00);
    rd_reg(3'd0, v);
    chk("R4 readback padding", v, 8'hF0);
  endtask

  task automatic t_modes;
    logic [7:0] v;
    wr_cmd(3'd4, 8'hA4);
    wr_cmd(3'd4, 8'h59);
    wr_cmd(3'd4, 8'hFE);
    wr_cmd(3'd4, 8'h03);
    chk("R10 transfer types", xfer_type_o, 8'h39);
    chk("R10 operating modes", op_mode_o, 8'h36);
    chk("R10 autoinit bits", {4'h0, autoinit_o}, 8'h06);
    chk("R10 decrement bits", {4'h0, decr_o}, 8'h05);
    rd_reg(3'd4, v); chk("R11 mode read ch0", v, 8'hA7);
    rd_reg(3'd4, v); chk("R11 mode read ch1", v, 8'h5B);
    rd_reg(3'd4, v); chk("R11 mode read ch2", v, 8'hFF);
    rd_reg(3'd4, v); chk("R11 mode read ch3", v, 8'h03);
    rd_reg(3'd4, v); chk("R11 mode read wraps to ch0", v, 8'hA7);
  endtask

  task automatic t_master_clear;
    logic [7:0] v;
    wr_cmd(3'd3, 8'h06);                 // software request ch2
    wr_cmd(3'd5, 8'h00);
    chk("R5 mask set by master clear", {4'h0, mask_o}, 8'h0F);
    chk("R5 request cleared by master clear", {4'h0, sw_req_o}, 8'h00);
    chk("R5 modes kept", xfer_type_o, 8'h39);
    rd_reg(3'd4, v);
    chk("R5 mode pointer back to ch0", v, 8'hA7);
  endtask

  task automatic t_eop;
    wr_cmd(3'd2, 8'h00);
    wr_cmd(3'd3, 8'h04); wr_cmd(3'd3, 8'h05);
    wr_cmd(3'd3, 8'h06); wr_cmd(3'd3, 8'h07);
    chk("R8 all requests set", {4'h0, sw_req_o}, 8'h0F);
    @(negedge clk); eop = 4'hF;
    @(negedge clk); eop = 4'h0;
    chk("R6 eop masks non-autoinit only", {4'h0, mask_o}, 8'h09);
    chk("R9 eop clears requests", {4'h0, sw_req_o}, 8'h00);
  endtask

  task automatic t_eop_collision;
    wr_cmd(3'd2, 8'h00, 4'h1);
    chk("R7 eop wins over clear-all", {4'h0, mask_o}, 8'h01);
  endtask

  task automatic t_request;
    logic [7:0] v;
    wr_cmd(3'd3, 8'h07);
    wr_cmd(3'd3, 8'h04);
    wr_cmd(3'd3, 8'hF3);                 // clear ch3, junk in 7:3
    chk("R8 request bits", {4'h0, sw_req_o}, 8'h01);
    rd_reg(3'd3, v);
    chk("R8 request readback", v, 8'hF1);
  endtask

  task automatic t_effective;
    // mask = 0001, software request = 0001
    @(negedge clk); hw_req = 4'h3;
    #2 chk("R12 hw 0011", {4'h0, eff_req_o}, 8'h03);
    @(negedge clk); hw_req = 4'h1;
    #2 chk("R12 masked hw with sw bypass", {4'h0, eff_req_o}, 8'h01);
    wr_cmd(3'd3, 8'h00);
    @(negedge clk); hw_req = 4'h1;
    #2 chk("R12 masked hw only", {4'h0, eff_req_o}, 8'h00);
    hw_req = 4'h0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    cmd_sel = 3'd0; wdata = 8'h00; eop = 4'h0; hw_req = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_mask_bits();
    t_mask_all();
    t_mask_clear();
    t_modes();
    t_master_clear();
    t_eop();
    t_eop_collision();
    t_request();
    t_effective();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule